// File: doc/BRIEF.md
# Host Command Serial Port

This block is the slave end of a four-wire control port through which a host processor configures and loads a signal-processing core. The host pulls chip select low, clocks in a 24-bit command word most significant bit first, then moves one to eight 24-bit data words in either direction, and finally releases chip select. The command carries a 16-bit target address, a direction flag, a burst length, and two control flags: one loads program memory, the other holds the core in soft reset.

All port pins are oversampled in the block's own clock domain. Write bursts become single-cycle register write strobes at consecutive addresses. A read command sends the acknowledge line busy while the block fetches the whole burst from the core into a local buffer. Once the buffer is full, acknowledge shows ready and the buffered words are shifted out on the data line. A program-load command ignores its address field and streams the low 16 bits of every following word into program memory from address zero. A command sent without any data words sets or clears the soft-reset level, and clearing it lets the core run.

Top module: `hcp_host_port`

## Requirements
- R1: Command word fields: bits 23..8 are the address, bit 6 is program load, bit 5 is soft reset, bit 4 is read (1) or write (0), and bits 3..0 hold the burst length minus one (0 means 1 word, 7 means 8 words). Bit 7 has no effect.
- R2: Serial data is taken on the rising edge of `sclk` while `cs_n` is low, MSB first. The first 24 bits after `cs_n` falls form the command word.
- R3: For a write command, data word k (k = 0 up to the length minus one) gives one `reg_wr` pulse with `reg_waddr` = command address + k and `reg_wdata` = that word. Data words beyond the burst length produce no write.
- R4: If `cs_n` goes high before the 24th bit of a word, that partial word is dropped without any write. The next transaction starts with a fresh command word.
- R5: After a read command, `ack_oe` goes low (line released, host must wait). The block issues one `reg_rd` at a time, at addresses base + 0 up to base + length minus one, each answered by `rd_valid`. `ack_oe` returns high only when all words of the burst have been stored.
- R6: During the data phase of a read, `dio_oe` is high and `dio_o` presents the stored words in order, MSB first. Each new bit appears after a falling `sclk` edge, and bit 23 of the first word is already present once `ack_oe` returns high.
- R7: A command with bit 6 set writes the low 16 bits of each following word to program memory. The first word goes to address 0 whatever the address field holds, and the address then advances by one per word. No write is made once the last program memory address (2^PRAM_AW − 1) has been filled.
- R8: A program-load command sets `soft_rst` as soon as the command word is complete. For any other command followed by no data words, `soft_rst` takes the value of bit 5 when `cs_n` rises.
- R9: After reset, `ack_oe` = 1 (ready), `dio_oe` = 0, `soft_rst` = 0, no request strobe is active, and `ack_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| dio_i | input | 1 | Data line as seen at the pad |
| dio_o | output | 1 | Data line drive value for reads |
| dio_oe | output | 1 | Data line drive enable |
| ack_o | output | 1 | Acknowledge drive value, held low (open drain) |
| ack_oe | output | 1 | Acknowledge pull-down enable; 1 = ready |
| reg_wr | output | 1 | Register write strobe |
| reg_waddr | output | 16 | Register write address |
| reg_wdata | output | 24 | Register write data |
| reg_rd | output | 1 | Register read request |
| reg_raddr | output | 16 | Register read address |
| rd_valid | input | 1 | Read response valid from the core |
| rd_data | input | 24 | Read response data |
| pram_we | output | 1 | Program memory write strobe |
| pram_addr | output | PRAM_AW | Program memory address |
| pram_wdata | output | 16 | Program memory write data |
| soft_rst | output | 1 | Soft reset level to the core |

## Verification
Several properties are checked on every cycle by the assertions. A received word always closes on a bit-counter boundary, and read requests never come back to back. The busy state of the acknowledge starts only from a decoded command. Soft reset is released only at a deselect, program writes happen only while soft reset is held, and the read output bit changes only on a falling clock or on buffer completion. Only the bench's scenarios can show that field decoding, burst address sequencing, the length cut-off, partial-word abort, the program-memory ceiling, and the exact order of bits on the read path give the right values.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int WORD_W    = 24;
  localparam int ADDR_W    = 16;
  localparam int PDATA_W   = 16;
  localparam int MAX_WORDS = 8;

  // Field positions are fixed by the serial frame
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              spare;
    logic              boot;
    logic              srst;
    logic              rd;
    logic [3:0]        len_m1;
  } hcp_cmd_t;
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hcp_rx.sv
module hcp_rx #(
  parameter int WORD_W = 24,
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rise,
  input  logic              din,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic [BW-1:0]     bcnt
);
  logic [WORD_W-1:0] sh_n;
  logic [BW-1:0]     cnt_n;
  logic              done_n;

  always_comb begin
    sh_n   = word;
    cnt_n  = bcnt;
    done_n = 1'b0;
    if (!sel) begin
      cnt_n = '0;
    end else if (rise) begin
      sh_n = {word[WORD_W-2:0], din};
      if (bcnt == BW'(WORD_W-1)) begin
        cnt_n  = '0;
        done_n = 1'b1;
      end else begin
        cnt_n = bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word      <= '0;
      bcnt      <= '0;
      word_done <= 1'b0;
    end else begin
      word      <= sh_n;
      bcnt      <= cnt_n;
      word_done <= done_n;
    end
  end

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (bcnt == '0));
endmodule

// File: rtl/hcp_rdbuf.sv
module hcp_rdbuf #(
  parameter int DEPTH = 8,
  parameter int W     = 24,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] last,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [W-1:0]  rd_data,
  output logic          busy,
  input  logic [IW-1:0] rix,
  output logic [W-1:0]  rword
);
  logic [W-1:0]  mem [DEPTH];
  logic          pend, pend_n, busy_n;
  logic [IW-1:0] ri, ri_n, last_q, last_n;
  logic [AW-1:0] base_q, base_n;
  logic          store;

  assign rd_req  = busy & ~pend;
  assign rd_addr = base_q + AW'(ri);
  assign store   = busy & pend & rd_valid;
  assign rword   = mem[rix];

  always_comb begin
    busy_n = busy;
    pend_n = pend;
    ri_n   = ri;
    last_n = last_q;
    base_n = base_q;
    if (start) begin
      busy_n = 1'b1;
      pend_n = 1'b0;
      ri_n   = '0;
      last_n = last;
      base_n = base;
    end else if (busy) begin
      if (rd_req) pend_n = 1'b1;
      if (store) begin
        pend_n = 1'b0;
        if (ri == last_q) busy_n = 1'b0;
        else              ri_n   = ri + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= 1'b0;
      ri     <= '0;
      last_q <= '0;
      base_q <= '0;
    end else begin
      busy   <= busy_n;
      pend   <= pend_n;
      ri     <= ri_n;
      last_q <= last_n;
      base_q <= base_n;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[ri] <= rd_data;
  end

  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
endmodule

// File: rtl/hcp_host_port.sv
module hcp_host_port
  import hcp_pkg::*;
#(
  parameter int PRAM_AW = 10,
  parameter int RDEPTH  = MAX_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               dio_i,
  output logic               dio_o,
  output logic               dio_oe,
  output logic               ack_o,
  output logic               ack_oe,
  output logic               reg_wr,
  output logic [ADDR_W-1:0]  reg_waddr,
  output logic [WORD_W-1:0]  reg_wdata,
  output logic               reg_rd,
  output logic [ADDR_W-1:0]  reg_raddr,
  input  logic               rd_valid,
  input  logic [WORD_W-1:0]  rd_data,
  output logic               pram_we,
  output logic [PRAM_AW-1:0] pram_addr,
  output logic [PDATA_W-1:0] pram_wdata,
  output logic               soft_rst
);
  localparam int IW  = $clog2(RDEPTH);
  localparam int WIW = IW + 1;
  localparam int BW  = $clog2(WORD_W);

  // reset: asynchronous assert, synchronous release
  logic rs1, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs1, srst_n} <= 2'b00;
    else        {rs1, srst_n} <= {1'b1, rs1};
  end

  // pin sampling and edge detection
  logic cs_s, sclk_s, din_s, cs_q, sclk_q;
  hcp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(srst_n), .d({cs_n, sclk, dio_i}), .q({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  logic sel, rise, fall, cs_rise;
  assign sel     = ~cs_s;
  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign cs_rise = cs_s & ~cs_q;

  // word receiver
  logic              word_done;
  logic [WORD_W-1:0] rx_word;
  logic [BW-1:0]     bcnt;
  hcp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(srst_n), .sel(sel), .rise(rise), .din(din_s),
    .word_done(word_done), .word(rx_word), .bcnt(bcnt)
  );

  hcp_cmd_t wcmd;
  assign wcmd = hcp_cmd_t'(rx_word);

  // state
  logic                have_cmd, have_cmd_n;
  hcp_cmd_t            cmd_q, cmd_n;
  logic [WIW-1:0]      widx, widx_n;
  logic                data_seen, data_seen_n;
  logic [PRAM_AW:0]    boot_idx, boot_idx_n;
  logic                srst_q, srst_n_v;
  logic                wr_n, pwe_n;
  logic [ADDR_W-1:0]   waddr_n;
  logic [WORD_W-1:0]   wdata_n;
  logic [PRAM_AW-1:0]  paddr_n;
  logic [PDATA_W-1:0]  pdata_n;
  logic                dout_q, dout_n;
  logic                busy_q;

  // read prefetch buffer
  logic              rb_start, rb_busy;
  logic [WORD_W-1:0] rword;
  assign rb_start = word_done & ~have_cmd & wcmd.rd & ~wcmd.boot;

  hcp_rdbuf #(.DEPTH(RDEPTH), .W(WORD_W), .AW(ADDR_W)) u_rdbuf (
    .clk(clk), .rst_n(srst_n), .start(rb_start), .base(wcmd.addr),
    .last(wcmd.len_m1[IW-1:0]), .rd_req(reg_rd), .rd_addr(reg_raddr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(rb_busy),
    .rix(widx[IW-1:0]), .rword(rword)
  );

  logic              busy_fall;
  logic [WORD_W-1:0] rshift;
  assign busy_fall = busy_q & ~rb_busy;
  assign rshift    = rword << bcnt;

  always_comb begin
    have_cmd_n  = have_cmd;
    cmd_n       = cmd_q;
    widx_n      = widx;
    data_seen_n = data_seen;
    boot_idx_n  = boot_idx;
    srst_n_v    = srst_q;
    wr_n        = 1'b0;
    pwe_n       = 1'b0;
    waddr_n     = reg_waddr;
    wdata_n     = reg_wdata;
    paddr_n     = pram_addr;
    pdata_n     = pram_wdata;
    dout_n      = dout_q;
    if (cs_rise) begin
      have_cmd_n = 1'b0;
      if (have_cmd && !data_seen && !cmd_q.boot) srst_n_v = cmd_q.srst;
    end else if (word_done) begin
      if (!have_cmd) begin
        have_cmd_n  = 1'b1;
        cmd_n       = wcmd;
        widx_n      = '0;
        data_seen_n = 1'b0;
        boot_idx_n  = '0;
        if (wcmd.boot) srst_n_v = 1'b1;
      end else begin
        data_seen_n = 1'b1;
        if (widx != WIW'(RDEPTH)) widx_n = widx + 1'b1;
        if (cmd_q.boot) begin
          if (!boot_idx[PRAM_AW]) begin
            pwe_n      = 1'b1;
            paddr_n    = boot_idx[PRAM_AW-1:0];
            pdata_n    = rx_word[PDATA_W-1:0];
            boot_idx_n = boot_idx + 1'b1;
          end
        end else if (!cmd_q.rd && (widx <= {1'b0, cmd_q.len_m1[IW-1:0]})) begin
          wr_n    = 1'b1;
          waddr_n = cmd_q.addr + ADDR_W'(widx);
          wdata_n = rx_word;
        end
      end
    end
    if ((fall || busy_fall) && have_cmd && cmd_q.rd) dout_n = rshift[WORD_W-1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      have_cmd   <= 1'b0;
      cmd_q      <= '0;
      widx       <= '0;
      data_seen  <= 1'b0;
      boot_idx   <= '0;
      srst_q     <= 1'b0;
      reg_wr     <= 1'b0;
      reg_waddr  <= '0;
      reg_wdata  <= '0;
      pram_we    <= 1'b0;
      pram_addr  <= '0;
      pram_wdata <= '0;
      dout_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      have_cmd   <= have_cmd_n;
      cmd_q      <= cmd_n;
      widx       <= widx_n;
      data_seen  <= data_seen_n;
      boot_idx   <= boot_idx_n;
      srst_q     <= srst_n_v;
      reg_wr     <= wr_n;
      reg_waddr  <= waddr_n;
      reg_wdata  <= wdata_n;
      pram_we    <= pwe_n;
      pram_addr  <= paddr_n;
      pram_wdata <= pdata_n;
      dout_q     <= dout_n;
      busy_q     <= rb_busy;
    end
  end

  assign soft_rst = srst_q;
  assign dio_o    = dout_q;
  assign dio_oe   = sel & have_cmd & cmd_q.rd & ~rb_busy;
  assign ack_o    = 1'b0;
  assign ack_oe   = ~rb_busy;

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rb_busy) |-> $past(word_done));
  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(srst_q) |-> $past(cs_rise));
  // R7
  pram_in_reset_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pram_we |-> srst_q);
  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    reg_wr |=> !reg_wr);
  // R6
  dout_edge_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(dout_q) |-> $past(fall | busy_fall));
endmodule

// File: tb/sim_hcp_host_port.sv
module sim_hcp_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam int PAW        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, dio_i = 1'b0;
  logic dio_o, dio_oe, ack_o, ack_oe, reg_wr, reg_rd, pram_we, soft_rst;
  logic [15:0] reg_waddr, reg_raddr, pram_wdata;
  logic [23:0] reg_wdata;
  logic [PAW-1:0] pram_addr;
  logic rd_valid = 1'b0;
  logic [23:0] rd_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcp_host_port #(.PRAM_AW(PAW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dio_i(dio_i),
    .dio_o(dio_o), .dio_oe(dio_oe), .ack_o(ack_o), .ack_oe(ack_oe),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_raddr(reg_raddr), .rd_valid(rd_valid), .rd_data(rd_data),
    .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata), .soft_rst(soft_rst)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // event logs
  logic [15:0] wa [64]; logic [23:0] wd [64]; int wn = 0;
  logic [15:0] pa [64]; logic [15:0] pd [64]; int pn = 0;
  logic [15:0] ra [64]; int rn = 0;
  bit busy_seen = 0;
  logic [15:0] rq_addr; int lat = 0;

  function automatic logic [23:0] rmodel(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a};
  endfunction

  always @(posedge clk) begin
    if (reg_wr && wn < 64) begin wa[wn] = reg_waddr; wd[wn] = reg_wdata; wn++; end
    if (pram_we && pn < 64) begin pa[pn] = 16'(pram_addr); pd[pn] = pram_wdata; pn++; end
    if (!ack_oe) busy_seen = 1;
    rd_valid <= 1'b0;
    if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin rd_valid <= 1'b1; rd_data <= rmodel(rq_addr); end
    end
    if (reg_rd) begin
      if (rn < 64) begin ra[rn] = reg_raddr; rn++; end
      rq_addr <= reg_raddr; lat <= 3;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    wn = 0; pn = 0; rn = 0; busy_seen = 0;
  endtask

  task automatic xfer(input logic [23:0] w, output logic [23:0] r);
    for (int i = 23; i >= 0; i--) begin
      dio_i = w[i];
      repeat (HP) @(negedge clk);
      r[i] = dio_o;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0; repeat (HP) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HP) @(negedge clk); cs_n = 1'b1; repeat (12) @(negedge clk);
  endtask

  task automatic wait_ready(output bit ok);
    ok = 0;
    for (int i = 0; i < 600; i++) begin
      if (ack_oe) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [23:0] r, cmd, dat;
    logic [15:0] base;
    int len;
    bit ok;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(ack_oe == 1'b1, "R9", "ack_oe in reset", 32'(ack_oe), 1);
    chk(dio_oe == 1'b0, "R9", "dio_oe in reset", 32'(dio_oe), 0);
    chk(soft_rst == 1'b0, "R9", "soft_rst in reset", 32'(soft_rst), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(ack_oe == 1'b1 && !reg_wr && !reg_rd && !pram_we, "R9", "idle after reset",
        {29'd0, ack_oe, reg_wr, reg_rd}, 32'h4);

    // R7 program load: address field ignored, stops at top of memory
    clear_logs();
    sel_on();
    xfer({16'h0ABC, 8'hE0}, r);   // bit 7 set too: R1 says no effect
    repeat (8) @(negedge clk);
    chk(soft_rst == 1'b1, "R8", "soft_rst set by load command", 32'(soft_rst), 1);
    for (int k = 0; k < (1 << PAW) + 2; k++) begin
      dat = 24'($urandom());
      pd[63] = dat[15:0];
      wd[63] = dat;
      xfer(dat, r);
      wa[62] = 16'(k);
      ra[62] = dat[15:0];
      repeat (4) @(negedge clk);
      if (k < (1 << PAW)) begin
        chk(pn == k + 1, "R7", "program write count", 32'(pn), 32'(k + 1));
        chk(pa[k] == 16'(k) && pd[k] == dat[15:0], "R7", "program addr/data",
            {pa[k], pd[k]}, {16'(k), dat[15:0]});
      end
    end
    sel_off();
    chk(pn == (1 << PAW), "R7", "no write past top address", 32'(pn), 32'(1 << PAW));
    chk(wn == 0, "R7", "no register write during load", 32'(wn), 0);
    chk(soft_rst == 1'b1, "R8", "soft_rst held after load", 32'(soft_rst), 1);

    // R8 command-only: clear, set, clear
    clear_logs();
    sel_on(); xfer(24'h000000, r); sel_off();
    chk(soft_rst == 1'b0, "R8", "soft reset cleared", 32'(soft_rst), 0);
    sel_on(); xfer(24'h123420, r); sel_off();
    chk(soft_rst == 1'b1, "R8", "soft reset set", 32'(soft_rst), 1);
    sel_on(); xfer(24'h123400, r); sel_off();
    chk(soft_rst == 1'b0, "R8", "soft reset cleared again", 32'(soft_rst), 0);
    chk(wn == 0 && pn == 0 && rn == 0, "R8", "command-only makes no access",
        32'(wn + pn + rn), 0);

    // R1 R3 write bursts, random lengths, one surplus word
    for (int t = 0; t < 5; t++) begin
      clear_logs();
      base = 16'($urandom());
      len  = (t == 0) ? 8 : (t == 1) ? 1 : int'($urandom_range(1, 8));
      cmd  = {base, 1'b0, 1'b0, 1'b0, 1'b0, 4'(len - 1)};
      sel_on();
      xfer(cmd, r);
      for (int k = 0; k < len + 1; k++) begin
        dat = 24'($urandom());
        wd[32 + k] = dat;
        xfer(dat, r);
      end
      sel_off();
      chk(wn == len, "R3", "write count", 32'(wn), 32'(len));
      for (int k = 0; k < len; k++)
        chk(wa[k] == base + 16'(k) && wd[k] == wd[32 + k], "R1",
            "write addr/data", {wa[k], 16'd0} | 32'(wd[k][15:0]),
            {base + 16'(k), 16'd0} | 32'(wd[32 + k][15:0]));
      chk(soft_rst == 1'b0, "R8", "data write leaves soft reset", 32'(soft_rst), 0);
    end

    // R4 abort mid-word
    clear_logs();
    sel_on();
    xfer(24'h4000_03, r);
    xfer(24'h00AA55, r);
    for (int i = 0; i < 10; i++) begin
      dio_i = 1'b1; repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
    end
    sel_off();
    chk(wn == 1, "R4", "partial word dropped", 32'(wn), 1);
    clear_logs();
    sel_on(); xfer(24'h5555_00, r); xfer(24'h0F0F0F, r); sel_off();
    chk(wn == 1 && wa[0] == 16'h5555 && wd[0] == 24'h0F0F0F, "R4",
        "fresh command after abort", {wa[0], wd[0][15:0]}, 32'h55550F0F);

    // R5 R6 read bursts
    for (int t = 0; t < 3; t++) begin
      clear_logs();
      base = 16'($urandom());
      len  = (t == 0) ? 8 : (t == 1) ? 1 : int'($urandom_range(2, 7));
      cmd  = {base, 1'b0, 1'b0, 1'b0, 1'b1, 4'(len - 1)};
      sel_on();
      xfer(cmd, r);
      wait_ready(ok);
      chk(busy_seen, "R5", "ack went busy after read command", 32'(busy_seen), 1);
      chk(ok, "R5", "ack returns ready", 32'(ok), 1);
      chk(rn == len, "R5", "read request count", 32'(rn), 32'(len));
      for (int k = 0; k < len && k < 64; k++)
        chk(ra[k] == base + 16'(k), "R5", "read request addr", 32'(ra[k]), 32'(base + 16'(k)));
      repeat (2) @(negedge clk);
      chk(dio_oe == 1'b1, "R6", "data line driven", 32'(dio_oe), 1);
      for (int k = 0; k < len; k++) begin
        xfer(24'h0, r);
        chk(r == rmodel(base + 16'(k)), "R6", "read word", 32'(r), 32'(rmodel(base + 16'(k))));
      end
      sel_off();
      chk(dio_oe == 1'b0, "R6", "data line released", 32'(dio_oe), 0);
      chk(wn == 0, "R5", "read makes no write", 32'(wn), 0);
    end

    chk(ack_o == 1'b0, "R9", "ack drive value", 32'(ack_o), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule